// File: doc/BRIEF.md
# Receive Descriptor Ring Consumer

This block owns a small ring of receive descriptors kept in local registers. Each entry carries a 32-bit status word and a buffer index. A receive engine posts a finished frame by writing a status word with the ownership flag set. The block looks only at the descriptor under its ring pointer and waits until that descriptor is owned.

For an owned descriptor the block decodes the status. It removes the four CRC bytes from the byte count and checks the acceptance flags. It then offers a record to a downstream consumer over a valid/ready handshake. The record holds the payload length, the buffer index, a corrupt flag and four error flags.

When the consumer accepts the record, the block re-arms the descriptor. It writes the buffer size back into the status word, which clears ownership, and restores the buffer index to the descriptor's own slot. It then steps the pointer to the next slot and pulses a restart output, so that an idle receive engine resumes. A read port shows any descriptor as it is currently held.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset the pointer is slot 0, every descriptor's status reads 1536 (0x600) with bit 31 clear, every buffer index equals its slot number, and `rec_valid_o` and `rx_restart_o` are low.
- R2: When no record is pending and the descriptor at the pointer has bit 31 set, `rec_valid_o` rises one cycle later. A descriptor at the pointer with bit 31 clear produces no record.
- R3: `rec_len_o` equals status bits 11:0 minus 4, taken modulo 4096.
- R4: `rec_bad_o` is 0 only when status bit 30 is 0, bit 27 is 1 and bit 22 is 0. Every other combination gives 1.
- R5: `rec_err_o` bit 3 carries status bit 26 (abort), bit 2 carries bit 25 (overrun), bit 1 carries bit 19 (CRC) and bit 0 carries bit 18 (alignment).
- R6: While `rec_valid_o` is high and `rec_ready_i` is low, the record stays valid and unchanged. `rec_buf_o` is the buffer index held by the descriptor when it was captured.
- R7: In the cycle after a handshake, the consumed descriptor reads status 1536 with bit 31 clear and buffer index equal to its slot, whether the frame was good or corrupt.
- R8: Descriptors are consumed strictly in slot order 0,1,2,3,0. An owned descriptor that is not at the pointer is not consumed until the pointer reaches it.
- R9: `rx_restart_o` is high for exactly the one cycle that follows each handshake, and low at all other times.
- R10: A write from the receive engine to the slot that is being re-armed in the same cycle is dropped, and the re-arm value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Receive engine writes a descriptor |
| wr_idx_i | input | 2 | Slot being written |
| wr_status_i | input | 32 | Status word written |
| wr_buf_i | input | 2 | Buffer index written |
| rd_idx_i | input | 2 | Slot selected on the read port |
| rd_status_o | output | 32 | Status word of the selected slot |
| rd_buf_o | output | 2 | Buffer index of the selected slot |
| rec_valid_o | output | 1 | Record offered |
| rec_ready_i | input | 1 | Consumer accepts the record |
| rec_len_o | output | 12 | Payload length without CRC |
| rec_buf_o | output | 2 | Buffer index of the frame |
| rec_bad_o | output | 1 | Frame is corrupt |
| rec_err_o | output | 4 | Abort, overrun, CRC and alignment flags |
| rx_restart_o | output | 1 | One-cycle receiver restart pulse |

## Verification
Frames are posted with several status patterns: one clean frame, then one frame each with More set, with PacketOK clear and with Long set. Each carries a different mix of error bits, so every acceptance term and every error lane is seen to matter on its own. A byte count below four separates a modulo subtraction from a saturating one. An owned descriptor is posted ahead of the pointer to tell ring order apart from first-owned order. A buffer index that does not match its slot shows that the index is restored on re-arm. Held-low ready and a write that lands in the same cycle as a re-arm test the record hold and the write priority.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  localparam int unsigned STAT_W    = 32;
  localparam int unsigned OWN_BIT   = 31;
  localparam int unsigned MORE_BIT  = 30;
  localparam int unsigned OK_BIT    = 27;
  localparam int unsigned ABORT_BIT = 26;
  localparam int unsigned OVER_BIT  = 25;
  localparam int unsigned LONG_BIT  = 22;
  localparam int unsigned CRC_BIT   = 19;
  localparam int unsigned ALIGN_BIT = 18;

  typedef struct packed {
    logic abort;
    logic overrun;
    logic crc;
    logic align;
  } rx_err_t;
endpackage

// File: rtl/rdr_desc_mem.sv
module rdr_desc_mem
  import rdr_pkg::*;
#(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned BUF_SIZE = 1536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [STAT_W-1:0] wr_status_i,
  input  logic [IDX_W-1:0]  wr_buf_i,
  input  logic              rearm_i,
  input  logic [IDX_W-1:0]  rearm_idx_i,
  input  logic [IDX_W-1:0]  cur_idx_i,
  output logic [STAT_W-1:0] cur_status_o,
  output logic [IDX_W-1:0]  cur_buf_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [STAT_W-1:0] rd_status_o,
  output logic [IDX_W-1:0]  rd_buf_o
);
  localparam logic [STAT_W-1:0] ARM_WORD = STAT_W'(BUF_SIZE);

  logic [STAT_W-1:0] stat_q [DEPTH];
  logic [IDX_W-1:0]  buf_q  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_q[g] <= ARM_WORD;
        buf_q[g]  <= SLOT;
      end else if (rearm_i && rearm_idx_i == SLOT) begin
        // re-arm has priority over an engine write to the same slot
        stat_q[g] <= ARM_WORD;
        buf_q[g]  <= SLOT;
      end else if (wr_en_i && wr_idx_i == SLOT) begin
        stat_q[g] <= wr_status_i;
        buf_q[g]  <= wr_buf_i;
      end
    end
  end

  assign cur_status_o = stat_q[cur_idx_i];
  assign cur_buf_o    = buf_q[cur_idx_i];
  assign rd_status_o  = stat_q[rd_idx_i];
  assign rd_buf_o     = buf_q[rd_idx_i];

  a_r7_rearm_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> stat_q[$past(rearm_idx_i)] == ARM_WORD
             && buf_q[$past(rearm_idx_i)] == $past(rearm_idx_i));
endmodule

// File: rtl/rdr_status_decode.sv
module rdr_status_decode
  import rdr_pkg::*;
#(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned CRC_BYTES = 4
) (
  input  logic [STAT_W-1:0] status_i,
  output logic              own_o,
  output logic [CNT_W-1:0]  len_o,
  output logic              bad_o,
  output rx_err_t           err_o
);
  logic status_unused;

  assign own_o = status_i[OWN_BIT];
  assign len_o = status_i[CNT_W-1:0] - CNT_W'(CRC_BYTES);
  // accept only More=0, PacketOK=1, Long=0
  assign bad_o = status_i[MORE_BIT] || !status_i[OK_BIT] || status_i[LONG_BIT];
  assign err_o = '{abort:   status_i[ABORT_BIT],
                   overrun: status_i[OVER_BIT],
                   crc:     status_i[CRC_BIT],
                   align:   status_i[ALIGN_BIT]};
  assign status_unused = ^status_i;
endmodule

// File: rtl/rdr_ring_ctrl.sv
module rdr_ring_ctrl
  import rdr_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned IDX_W = 2,
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             own_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             bad_i,
  input  rx_err_t          err_i,
  input  logic [IDX_W-1:0] buf_i,
  input  logic             rec_ready_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             rec_valid_o,
  output logic [CNT_W-1:0] rec_len_o,
  output logic [IDX_W-1:0] rec_buf_o,
  output logic             rec_bad_o,
  output rx_err_t          rec_err_o,
  output logic             rearm_o,
  output logic             restart_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] ptr_q;
  logic             valid_q;
  logic             restart_q;
  logic             take;

  assign take    = !valid_q && own_i;
  assign rearm_o = valid_q && rec_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      valid_q   <= 1'b0;
      restart_q <= 1'b0;
      rec_len_o <= '0;
      rec_buf_o <= '0;
      rec_bad_o <= 1'b0;
      rec_err_o <= '0;
    end else begin
      restart_q <= rearm_o;
      if (take) begin
        valid_q   <= 1'b1;
        rec_len_o <= len_i;
        rec_buf_o <= buf_i;
        rec_bad_o <= bad_i;
        rec_err_o <= err_i;
      end else if (rearm_o) begin
        valid_q <= 1'b0;
        ptr_q   <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  assign ptr_o       = ptr_q;
  assign rec_valid_o = valid_q;
  assign restart_o   = restart_q;

  a_r2_rise_needs_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(own_i));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !rec_ready_i) |=> valid_q && $stable(rec_len_o) && $stable(rec_buf_o)
      && $stable(rec_bad_o) && $stable(rec_err_o));
  a_r8_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_o |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));
  a_r8_ptr_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rearm_o |=> $stable(ptr_q));
  a_r9_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_o |=> restart_q);
  a_r9_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_q |=> !restart_q);
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rdr_pkg::*;
#(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned BUF_SIZE  = 1536,
  parameter int unsigned CRC_BYTES = 4,
  localparam int unsigned IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned ERR_W    = $bits(rx_err_t)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [STAT_W-1:0] wr_status_i,
  input  logic [IDX_W-1:0]  wr_buf_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [STAT_W-1:0] rd_status_o,
  output logic [IDX_W-1:0]  rd_buf_o,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [CNT_W-1:0]  rec_len_o,
  output logic [IDX_W-1:0]  rec_buf_o,
  output logic              rec_bad_o,
  output logic [ERR_W-1:0]  rec_err_o,
  output logic              rx_restart_o
);
  logic [IDX_W-1:0]  ptr;
  logic [STAT_W-1:0] cur_status;
  logic [IDX_W-1:0]  cur_buf;
  logic              own, bad, rearm;
  logic [CNT_W-1:0]  len;
  rx_err_t           err, rec_err;

  rdr_desc_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W), .BUF_SIZE(BUF_SIZE)) u_mem (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_status_i, .wr_buf_i,
    .rearm_i(rearm), .rearm_idx_i(ptr), .cur_idx_i(ptr),
    .cur_status_o(cur_status), .cur_buf_o(cur_buf),
    .rd_idx_i, .rd_status_o, .rd_buf_o);

  rdr_status_decode #(.CNT_W(CNT_W), .CRC_BYTES(CRC_BYTES)) u_dec (
    .status_i(cur_status), .own_o(own), .len_o(len), .bad_o(bad), .err_o(err));

  rdr_ring_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .own_i(own), .len_i(len), .bad_i(bad), .err_i(err),
    .buf_i(cur_buf), .rec_ready_i, .ptr_o(ptr), .rec_valid_o, .rec_len_o,
    .rec_buf_o, .rec_bad_o, .rec_err_o(rec_err), .rearm_o(rearm),
    .restart_o(rx_restart_o));

  assign rec_err_o = rec_err;

  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_restart_o |-> $past(rec_valid_o && rec_ready_i));
  a_r7_disowned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_restart_o |-> !rec_valid_o);
endmodule

// File: tb/tb_rx_desc_ring.sv
module tb_rx_desc_ring;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_status = '0;
  logic [1:0]  wr_buf = '0;
  logic [1:0]  rd_idx;
  logic [31:0] rd_status;
  logic [1:0]  rd_buf;
  logic        rec_valid, rec_ready = 1'b1, rec_bad, restart;
  logic [11:0] rec_len;
  logic [1:0]  rec_buf;
  logic [3:0]  rec_err;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic [1:0] rd_rot = '0;
  logic       rd_force = 1'b0;
  logic [1:0] rd_force_idx = '0;
  assign rd_idx = rd_force ? rd_force_idx : rd_rot;

  always #5 clk = ~clk;

  rx_desc_ring dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_status_i(wr_status), .wr_buf_i(wr_buf), .rd_idx_i(rd_idx),
    .rd_status_o(rd_status), .rd_buf_o(rd_buf), .rec_valid_o(rec_valid),
    .rec_ready_i(rec_ready), .rec_len_o(rec_len), .rec_buf_o(rec_buf),
    .rec_bad_o(rec_bad), .rec_err_o(rec_err), .rx_restart_o(restart));

  // behavioural reference
  int unsigned m_stat [4];
  int          m_buf  [4];
  int          m_ptr, m_valid, m_len, m_buf_rec, m_bad, m_err, m_restart;

  always @(posedge clk) begin
    rd_rot <= rd_rot + 2'd1;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_stat[i] = 1536; m_buf[i] = i; end
      m_ptr = 0; m_valid = 0; m_restart = 0;
      m_len = 0; m_buf_rec = 0; m_bad = 0; m_err = 0;
    end else begin
      int unsigned s;
      bit hs;
      hs = (m_valid == 1) && rec_ready;
      s  = m_stat[m_ptr];
      if (m_valid == 0 && s[31]) begin
        m_valid = 1;
        m_len = ((s & 32'hFFF) + 4096 - 4) % 4096;
        m_buf_rec = m_buf[m_ptr];
        m_bad = !(s[30] == 0 && s[27] == 1 && s[22] == 0);
        m_err = {s[26], s[25], s[19], s[18]};
      end
      if (wr_en) begin m_stat[wr_idx] = wr_status; m_buf[wr_idx] = wr_buf; end
      m_restart = hs;
      if (hs) begin
        m_stat[m_ptr] = 1536; m_buf[m_ptr] = m_ptr;
        m_ptr = (m_ptr + 1) % 4; m_valid = 0;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R2 rec_valid", 32'(rec_valid), 32'(m_valid));
    chk("R9 restart", 32'(restart), 32'(m_restart));
    chk("R7 rd_status", rd_status, m_stat[rd_idx]);
    chk("R7 rd_buf", 32'(rd_buf), 32'(m_buf[rd_idx]));
    if (m_valid == 1) begin
      chk("R3 rec_len", 32'(rec_len), 32'(m_len));
      chk("R6 rec_buf", 32'(rec_buf), 32'(m_buf_rec));
      chk("R4 rec_bad", 32'(rec_bad), 32'(m_bad));
      chk("R5 rec_err", 32'(rec_err), 32'(m_err));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic post(logic [1:0] idx, logic [31:0] st, logic [1:0] b);
    wr_en = 1'b1; wr_idx = idx; wr_status = st; wr_buf = b;
    tick();
    wr_en = 1'b0;
  endtask

  localparam logic [31:0] OWN = 32'h8000_0000, OK = 32'h0800_0000;

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    rd_force = 1'b1;
    for (int i = 0; i < 4; i++) begin
      rd_force_idx = 2'(i);
      #1;
      chk("R1 reset status", rd_status, 32'd1536);
      chk("R1 reset buf", 32'(rd_buf), i);
    end
    chk("R1 reset valid", 32'(rec_valid), 0);
    rd_force = 1'b0;
    tick();
    // R4 good, R3 length
    post(2'd0, OWN | OK | 32'd64, 2'd0);
    tick();
    chk("R3 len 64", 32'(rec_len), 60);
    chk("R4 good", 32'(rec_bad), 0);
    tick(3);
    // R4 More set, R5 abort+crc
    post(2'd1, OWN | OK | 32'h4000_0000 | 32'h0400_0000 | 32'h0008_0000 | 32'd100, 2'd1);
    tick();
    chk("R4 more bad", 32'(rec_bad), 1);
    chk("R5 abort crc", 32'(rec_err), 32'b1010);
    tick(3);
    post(2'd2, OWN | 32'h0200_0000 | 32'd80, 2'd2);
    tick();
    chk("R4 ok clear bad", 32'(rec_bad), 1);
    tick(3);
    post(2'd3, OWN | OK | 32'h0040_0000 | 32'h0004_0000 | 32'd90, 2'd3);
    tick();
    chk("R4 long bad", 32'(rec_bad), 1);
    chk("R5 align", 32'(rec_err), 32'b0001);
    tick(3);
    // R3 wrap below four, R6 hold, slot 0 after wrap (R8)
    rec_ready = 1'b0;
    post(2'd0, OWN | OK | 32'd3, 2'd3);
    tick(4);
    chk("R6 held valid", 32'(rec_valid), 1);
    chk("R3 len wrap", 32'(rec_len), 4095);
    chk("R6 buf index", 32'(rec_buf), 3);
    rec_ready = 1'b1;
    tick();
    rec_ready = 1'b0;
    chk("R9 restart", 32'(restart), 1);
    rd_force = 1'b1; rd_force_idx = 2'd0; #1;
    chk("R7 buf restored", 32'(rd_buf), 0);
    chk("R7 status rearmed", rd_status, 32'd1536);
    rd_force = 1'b0;
    rec_ready = 1'b1;
    tick(2);
    chk("R9 single", 32'(restart), 0);
    // R8 order: slot 2 owned ahead of pointer at 1
    post(2'd2, OWN | OK | 32'd20, 2'd2);
    tick(3);
    chk("R8 no skip", 32'(rec_valid), 0);
    // R2 ownership clear ignored
    post(2'd1, OK | 32'd50, 2'd1);
    tick(2);
    chk("R2 no own", 32'(rec_valid), 0);
    post(2'd1, OWN | OK | 32'd50, 2'd1);
    tick(6);
    // R10 collision at slot 3
    rec_ready = 1'b0;
    post(2'd3, OWN | OK | 32'd40, 2'd3);
    tick(2);
    wr_en = 1'b1; wr_idx = 2'd3; wr_status = OWN | OK | 32'd77; wr_buf = 2'd1;
    rec_ready = 1'b1;
    tick();
    wr_en = 1'b0;
    rd_force = 1'b1; rd_force_idx = 2'd3; #1;
    chk("R10 rearm wins", rd_status, 32'd1536);
    chk("R10 buf kept", 32'(rd_buf), 3);
    rd_force = 1'b0;
    tick(4);
    chk("R10 no record", 32'(rec_valid), 0);
    // burst round the ring
    for (int k = 0; k < 8; k++) begin
      post(2'(k), OWN | OK | 32'(k * 8 + 10), 2'(k));
      rec_ready = (k % 2 == 0);
      tick(2);
      rec_ready = 1'b1;
      tick(2);
    end
    tick(5);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule